// File: doc/BRIEF.md
# Multi-Mode Timer Counter with Prescaler

This block is a 16-bit timebase for a set of capture/compare channels. It takes a clock-enable tick from one of four source inputs and passes it through a power-of-two prescaler. The divided tick then advances a counter in one of four run modes. The modes are halted, wrap at a programmable period, free-running over the full 16-bit range, and triangular. In triangular mode the counter climbs to the period and falls back to zero, which gives center-aligned PWM.

The block outputs the live count and the counting direction. It also gives a one-cycle match strobe for the period value, which compare channels use to reload or reset their outputs. An overflow event sets a sticky flag. The flag drives an interrupt request only when its enable input is high, and it is cleared by a dedicated strobe. A separate clear strobe restarts the count, the direction and the prescaler.

Top module: `tmr_core`

## Requirements
- R1: With `runMode` = 00 the count and direction hold, the prescaler does not advance, and `periodEq` stays low.
- R2: With `runMode` = 01 each divided tick adds one to the count. A tick taken while the count is at or above `period` loads 0 and raises the overflow event.
- R3: With `runMode` = 10 each divided tick adds one to the count, ignoring `period`. The tick taken at 0xFFFF wraps the count to 0 and raises the overflow event.
- R4: With `runMode` = 11 and `period` P > 0, the count rises to P and then falls to 0. `countDown` is 1 from the tick that reaches P until the tick that reaches 0, so one cycle takes 2·P ticks. The tick that brings the count down to 0 raises the overflow event. With P = 0 the count is held at 0.
- R5: `divSel` 00/01/10/11 makes the count advance once per 1/2/4/8 selected source ticks.
- R6: `srcSel` value k (0 to 3) selects `tickSrc[k]` as the source tick, and the other source inputs have no effect.
- R7: A one-cycle `clrReq` loads count 0, sets direction up and restarts the prescaler. It takes priority over a tick in the same cycle and leaves the overflow flag unchanged.
- R8: `ovfFlag` is set by an overflow event and stays set until `ovfClr`. An event wins over `ovfClr` in the same cycle. `ovfIrq` equals `ovfFlag` AND `ovfIntEn`.
- R9: `periodEq` is high in exactly those cycles in which a divided tick occurs while the count equals `period`.
- R10: In any mode other than 11, `countDown` is 0 from the cycle after the mode is set.
- R11: After reset the count, direction, prescaler and overflow flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickSrc | input | 4 | Four candidate clock-enable tick inputs |
| srcSel | input | 2 | Index of the tick input used |
| divSel | input | 2 | Prescaler select: divide by 1, 2, 4, 8 |
| runMode | input | 2 | 00 halt, 01 wrap at period, 10 free run, 11 triangle |
| clrReq | input | 1 | One-cycle clear strobe |
| ovfIntEn | input | 1 | Overflow interrupt enable |
| ovfClr | input | 1 | Clear strobe for the overflow flag |
| period | input | 16 | Period (compare register 0) value |
| count | output | 16 | Current count |
| countDown | output | 1 | 1 while counting down in triangle mode |
| periodEq | output | 1 | Tick-wide match of count with period |
| ovfFlag | output | 1 | Sticky overflow flag |
| ovfIrq | output | 1 | Gated interrupt request |

## Verification
On every cycle the assertions check several properties. The count holds without a tick or clear. A clear leaves count 0 and direction up. A free-run wrap from 0xFFFF sets the flag. The direction is up outside triangle mode. The flag stays set without a clear strobe. Two divided ticks never occur back to back when the divider is above one. The exact count sequences need the bench's reference model and its scenarios to show them. These include the wrap point in each mode, the turnaround and the 2·P cycle length in triangle mode, and the divide ratios. The same holds for source selection, the clear-versus-tick and event-versus-clear priorities, and the timing of the match strobe.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_HALT   = 2'b00,
    MODE_PERIOD = 2'b01,
    MODE_FREE   = 2'b10,
    MODE_TRI    = 2'b11
  } tmrMode_e;

  typedef struct packed {
    logic tick;
    logic clear;
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = 2,
  parameter int PRE_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] tickSrc,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic [1:0]         divSel,
  input  tmrMode_e           mode,
  input  logic               clrReq,
  output tmrStrobe_t         st
);
  logic             srcTick;
  logic             running;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLim;

  assign srcTick = tickSrc[srcSel];
  assign running = (mode != MODE_HALT);
  // divide-by-2^divSel needs a terminal value of 2^divSel - 1
  assign preLim  = ~({PRE_W{1'b1}} << divSel);

  always_comb begin
    st.clear = clrReq;
    st.tick  = running && srcTick && !clrReq && (preCnt >= preLim);
  end

  always_ff @(posedge clk) begin
    if (!rstN || clrReq)            preCnt <= '0;
    else if (running && srcTick)    preCnt <= st.tick ? '0 : preCnt + 1'b1;
  end

  // R5: with a divider above one, divided ticks are never adjacent
  assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rstN)
    (st.tick && divSel != 2'b00) |=> (!st.tick || divSel == 2'b00));

  // R1: halted mode produces no divided tick
  assert_halt_no_tick_R1: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_HALT) |-> !st.tick);
endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       st,
  input  tmrMode_e         mode,
  input  logic [CNT_W-1:0] period,
  input  logic             ovfClr,
  output logic [CNT_W-1:0] count,
  output logic             countDown,
  output logic             periodEq,
  output logic             ovfFlag
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cntNext;
  logic             dirNext;
  logic             ovfEvent;

  always_comb begin
    cntNext  = count;
    dirNext  = countDown;
    ovfEvent = 1'b0;
    if (st.clear) begin
      cntNext = '0;
      dirNext = 1'b0;
    end else begin
      if (mode != MODE_TRI) dirNext = 1'b0;
      if (st.tick) begin
        unique case (mode)
          MODE_PERIOD: begin
            if (count >= period) begin
              cntNext  = '0;
              ovfEvent = 1'b1;
            end else begin
              cntNext = count + 1'b1;
            end
          end
          MODE_FREE: begin
            cntNext  = count + 1'b1;
            ovfEvent = (count == CNT_MAX);
          end
          MODE_TRI: begin
            if (period == '0) begin
              cntNext = '0;
              dirNext = 1'b0;
            end else if (countDown) begin
              if (count == '0) begin
                dirNext = 1'b0;
              end else begin
                cntNext = count - 1'b1;
                if (count == CNT_ONE) begin
                  dirNext  = 1'b0;
                  ovfEvent = 1'b1;
                end
              end
            end else if (count >= period) begin
              cntNext = count - 1'b1;
              dirNext = 1'b1;
            end else begin
              cntNext = count + 1'b1;
              if (count + 1'b1 == period) dirNext = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      countDown <= 1'b0;
      ovfFlag   <= 1'b0;
    end else begin
      count     <= cntNext;
      countDown <= dirNext;
      if (ovfEvent)    ovfFlag <= 1'b1;
      else if (ovfClr) ovfFlag <= 1'b0;
    end
  end

  assign periodEq = st.tick && (count == period);

  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!st.tick && !st.clear) |=> (count == $past(count)));

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    st.clear |=> (count == '0 && !countDown));

  assert_free_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (st.tick && !st.clear && mode == MODE_FREE && count == CNT_MAX)
      |=> (count == '0 && ovfFlag));

  assert_dir_up_R10: assert property (@(posedge clk) disable iff (!rstN)
    (mode != MODE_TRI) |=> !countDown);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag);
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_SRC = 4,
  parameter int MAX_DIV_LOG = 3,
  localparam int SEL_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] tickSrc,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic [1:0]         divSel,
  input  logic [1:0]         runMode,
  input  logic               clrReq,
  input  logic               ovfIntEn,
  input  logic               ovfClr,
  input  logic [CNT_W-1:0]   period,
  output logic [CNT_W-1:0]   count,
  output logic               countDown,
  output logic               periodEq,
  output logic               ovfFlag,
  output logic               ovfIrq
);
  tmrStrobe_t strobes;
  tmrMode_e   mode;

  assign mode = tmrMode_e'(runMode);

  tmr_ctrl #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .PRE_W(MAX_DIV_LOG)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickSrc(tickSrc), .srcSel(srcSel),
    .divSel(divSel), .mode(mode), .clrReq(clrReq), .st(strobes)
  );

  tmr_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(strobes), .mode(mode), .period(period),
    .ovfClr(ovfClr), .count(count), .countDown(countDown),
    .periodEq(periodEq), .ovfFlag(ovfFlag)
  );

  assign ovfIrq = ovfFlag & ovfIntEn;
endmodule

// File: tb/sim_tmr_core.sv
module sim_tmr_core;
  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  tickSrc;
  logic [1:0]  srcSel, divSel, runMode;
  logic        clrReq, ovfIntEn, ovfClr;
  logic [15:0] period;
  logic [15:0] count;
  logic        countDown, periodEq, ovfFlag, ovfIrq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // reference state
  logic [15:0] mCnt;
  logic        mDir, mFlag;
  int          mPre;

  always #4 clk = ~clk;

  tmr_core u0 (
    .clk(clk), .rstN(rstN), .tickSrc(tickSrc), .srcSel(srcSel),
    .divSel(divSel), .runMode(runMode), .clrReq(clrReq),
    .ovfIntEn(ovfIntEn), .ovfClr(ovfClr), .period(period),
    .count(count), .countDown(countDown), .periodEq(periodEq),
    .ovfFlag(ovfFlag), .ovfIrq(ovfIrq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      if (failures < 30)
        $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  function automatic bit refTick();
    int lim;
    lim = (1 << divSel) - 1;
    return (runMode != 2'b00) && tickSrc[srcSel] && !clrReq && (mPre >= lim);
  endfunction

  function automatic string modeTag();
    case (runMode)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic refStep();
    bit tk, ev;
    tk = refTick();
    ev = 1'b0;
    if (clrReq) mPre = 0;
    else if (runMode != 2'b00 && tickSrc[srcSel]) mPre = tk ? 0 : mPre + 1;
    if (clrReq) begin
      mCnt = 16'd0; mDir = 1'b0;
    end else begin
      if (runMode != 2'b11) mDir = 1'b0;
      if (tk) begin
        case (runMode)
          2'b01: if (mCnt >= period) begin mCnt = 0; ev = 1; end else mCnt = mCnt + 1;
          2'b10: begin ev = (mCnt == 16'hFFFF); mCnt = mCnt + 1; end
          2'b11: begin
            if (period == 0) begin mCnt = 0; mDir = 0; end
            else if (mDir) begin
              if (mCnt == 0) mDir = 0;
              else begin
                mCnt = mCnt - 1;
                if (mCnt == 0) begin mDir = 0; ev = 1; end
              end
            end else if (mCnt >= period) begin mCnt = mCnt - 1; mDir = 1; end
            else begin mCnt = mCnt + 1; if (mCnt == period) mDir = 1; end
          end
          default: ;
        endcase
      end
    end
    if (ev) mFlag = 1'b1;
    else if (ovfClr) mFlag = 1'b0;
  endtask

  task automatic compareAll();
    check({modeTag(), " count"}, count, mCnt);
    check(runMode == 2'b11 ? "R4 dir" : "R10 dir", countDown, mDir);
    check("R8 flag", ovfFlag, mFlag);
    check("R8 irq", ovfIrq, mFlag & ovfIntEn);
    check("R9 periodEq", periodEq, refTick() && (mCnt == period));
  endtask

  // advance one clock with current inputs, then compare at the falling edge
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    cycles++;
    refStep();
    compareAll();
    clrReq = 1'b0;
    ovfClr = 1'b0;
  endtask

  task automatic runN(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic doClear();
    clrReq = 1'b1;
    cycle();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    logic [15:0] c0;
    void'($urandom(32'd20240611));
    rstN = 1'b0; tickSrc = 4'h0; srcSel = 0; divSel = 0; runMode = 0;
    clrReq = 0; ovfIntEn = 0; ovfClr = 0; period = 0;
    mCnt = 0; mDir = 0; mFlag = 0; mPre = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 count", count, 0);
    check("R11 dir", countDown, 0);
    check("R11 flag", ovfFlag, 0);
    rstN = 1'b1;

    // R1: halted with ticks present
    tickSrc = 4'hF; runN(10);
    check("R1 halted count", count, 0);

    // R3: free-run wrap past 0xFFFF
    runMode = 2'b10; period = 16'd100; ovfIntEn = 1'b1;
    runN(65536);
    check("R3 wrapped count", count, 0);
    check("R3 flag after wrap", ovfFlag, 1);
    ovfClr = 1'b1; cycle();
    check("R8 flag cleared", ovfFlag, 0);

    // R7: clear has priority over a tick
    clrReq = 1'b1; cycle();
    check("R7 clear count", count, 0);
    check("R7 clear dir", countDown, 0);

    // R2: wrap at period 5
    runMode = 2'b01; period = 16'd5; doClear();
    runN(6);
    check("R2 wrap to zero", count, 0);
    check("R2 flag on wrap", ovfFlag, 1);
    ovfClr = 1'b1; cycle();

    // R4: triangle with period 3, 2*P ticks per cycle
    runMode = 2'b11; period = 16'd3; doClear();
    runN(3);
    check("R4 peak", count, 3);
    check("R4 down at peak", countDown, 1);
    runN(3);
    check("R4 back to zero", count, 0);
    check("R4 up again", countDown, 0);
    check("R4 flag at zero", ovfFlag, 1);

    // R5: divide by 4
    runMode = 2'b10; divSel = 2'b10; doClear();
    runN(8);
    check("R5 div4 advance", count, 2);
    divSel = 2'b11; doClear();
    runN(16);
    check("R5 div8 advance", count, 2);

    // R6: only the selected source counts
    divSel = 2'b00; srcSel = 2'd2; doClear();
    c0 = count;
    tickSrc = 4'b1011; runN(5);
    check("R6 unselected sources ignored", count, c0);
    tickSrc = 4'b0100; runN(5);
    check("R6 selected source counts", count, c0 + 5);

    // R8: event wins over clear in the same cycle
    runMode = 2'b01; period = 16'd2; tickSrc = 4'hF; doClear();
    runN(2);
    ovfClr = 1'b1; cycle();
    check("R8 event beats clear", ovfFlag, 1);

    // constrained random
    for (int i = 0; i < 20000; i++) begin
      tickSrc = 4'($urandom());
      if ($urandom_range(0, 199) == 0) runMode = 2'($urandom());
      if ($urandom_range(0, 149) == 0) divSel = 2'($urandom());
      if ($urandom_range(0, 99) == 0) srcSel = 2'($urandom());
      if ($urandom_range(0, 299) == 0) period = 16'($urandom_range(0, 12));
      if ($urandom_range(0, 49) == 0) ovfIntEn = 1'($urandom());
      clrReq = ($urandom_range(0, 119) == 0);
      ovfClr = ($urandom_range(0, 19) == 0);
      cycle();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule